// File: doc/BRIEF.md
# Sync-Bit Destuffing Packet Framer

This block sits behind a bit-recovery stage. Each received bit arrives with a valid strobe. The line code places a short group of sync bits after every group of data bits, so the received stream alternates between the two kinds of group. The stream always opens with a data group.

The framer removes the sync bits and checks the one sync bit that carries information. It packs the data bits into bytes, most significant bit first. Each finished byte goes out on a write port, together with its index inside the packet. The low bits of the first byte give the packet length in bytes. When that many bytes have been written, the block raises a one-cycle done strobe that carries the length, and it stops receiving.

Two faults stop reception early and raise a sticky flag:
- too many sync violations inside one sync group;
- a packet that would grow past the buffer capacity.

A frame-start pulse arms the block and clears its state. Validating the packet CRC is left to logic further downstream.

Top module: `sync_destuff_framer`

## Requirements
- R1: After reset, `busy`, `wr_en`, `pkt_done`, `wrong_pkt` and `overflow` are 0. Bits presented before the first `frame_start` produce no write and no flag.
- R2: A `frame_start` pulse raises `busy` in the next cycle and clears `wrong_pkt`, `overflow`, the length and all counters. A bit presented in the same cycle as `frame_start` is dropped.
- R3: Data bits fill each byte MSB first. The cycle after the 8th data bit of a byte is accepted, `wr_en` is 1 for one cycle, with `wr_data` set to the byte and `wr_addr` set to its index, counting from 0.
- R4: Each 8 data bits are followed by a group of 3 sync bits. Sync bits are never written, and the next data byte starts right after the group.
- R5: The first sync bit of a group must differ from the last data bit. A bit equal to the last data bit is discarded: it is not consumed, and it raises that group's error count. The next bit is checked again as the first sync bit.
- R6: Once the first sync bit has been accepted, the 2nd and 3rd sync bits are accepted whatever their values.
- R7: The error count restarts with every sync group. A 3rd error within one group sets `wrong_pkt`, clears `busy`, and stops all further writes.
- R8: The packet length is bits [4:0] of byte 0. If the length is non-zero, `pkt_done` pulses for one cycle together with the write of byte length-1. `pkt_len` then holds the length, and `busy` drops.
- R9: A length of 0 never completes. A data bit arriving when 38 bytes are already written sets `overflow`, is not written, and clears `busy`. `wr_addr` never reaches 38.
- R10: After completion, a wrong packet or an overflow, any further bits cause no write and no strobe until the next `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Arms the block and clears its state |
| bit_valid | input | 1 | A recovered bit is present |
| bit_in | input | 1 | Recovered bit value |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 6 | Byte index in the packet |
| wr_data | output | 8 | Assembled byte |
| pkt_done | output | 1 | One-cycle packet completion strobe |
| pkt_len | output | 5 | Length of the completed packet in bytes |
| wrong_pkt | output | 1 | Sticky flag: sync violation limit reached |
| overflow | output | 1 | Sticky flag: buffer capacity exceeded |
| busy | output | 1 | Reception active |

## Verification
The assertions check the following on every cycle:
- writes happen only while reception is active;
- the done strobe lasts one cycle, and it coincides with the write of the last byte;
- the done strobe and the two fault flags never rise together;
- reception stops on every terminating event;
- the byte index stays below the capacity.

Some properties only the bench scenarios can show:
- the bytes are rebuilt with the right bit order;
- a sync bit that repeats the last data bit is dropped without losing byte alignment;
- the error count restarts in every group;
- each packet completes at the length in its first byte.

The bench shows these by sweeping every length from 1 to 31 and by driving a zero-length packet to the capacity limit.

// File: rtl/framer_pkg.sv
package framer_pkg;
  typedef enum logic {PH_DATA = 1'b0, PH_SYNC = 1'b1} phase_e;
endpackage

// File: rtl/fr_sync_tracker.sv
// Tracks the data/sync group phase, the most recent data bit, and the per-group sync error count.
module fr_sync_tracker
  import framer_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int SYNC_BITS = 3,
  parameter int ERR_LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic take,
  input  logic bit_in,
  output logic data_take,
  output logic byte_end,
  output logic sync_fail
);
  localparam int GMAX = (DATA_BITS > SYNC_BITS) ? DATA_BITS : SYNC_BITS;
  localparam int CW   = (GMAX > 1) ? $clog2(GMAX) : 1;
  localparam int EW   = $clog2(ERR_LIMIT + 1);

  phase_e          phase_q, phase_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [EW-1:0]   err_q, err_n;
  logic            last_q, last_n;

  always_comb begin
    phase_n   = phase_q;
    cnt_n     = cnt_q;
    err_n     = err_q;
    last_n    = last_q;
    data_take = 1'b0;
    byte_end  = 1'b0;
    sync_fail = 1'b0;
    if (take) begin
      if (phase_q == PH_DATA) begin
        data_take = 1'b1;
        last_n    = bit_in;
        if (cnt_q == CW'(DATA_BITS - 1)) begin
          byte_end = 1'b1;
          phase_n  = PH_SYNC;
          cnt_n    = '0;
          err_n    = '0;
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end else if (cnt_q == '0 && bit_in == last_q) begin
        // first sync bit repeats the data bit: drop it, count an error
        err_n = err_q + EW'(1);
        if (err_q == EW'(ERR_LIMIT - 1)) sync_fail = 1'b1;
      end else if (cnt_q == CW'(SYNC_BITS - 1)) begin
        phase_n = PH_DATA;
        cnt_n   = '0;
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_DATA;
      cnt_q   <= '0;
      err_q   <= '0;
      last_q  <= 1'b0;
    end else if (clear) begin
      phase_q <= PH_DATA;
      cnt_q   <= '0;
      err_q   <= '0;
      last_q  <= 1'b0;
    end else if (take) begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      err_q   <= err_n;
      last_q  <= last_n;
    end
  end
endmodule

// File: rtl/fr_byte_assembler.sv
// Shifts data bits in MSB first and issues a registered byte write at the end of each byte.
module fr_byte_assembler #(
  parameter int DATA_BITS = 8,
  parameter int MAX_BYTES = 38,
  parameter int AW        = 6,
  parameter int CNTW      = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 take,
  input  logic                 close,
  input  logic                 bit_in,
  output logic [DATA_BITS-1:0] byte_next,
  output logic [CNTW-1:0]      byte_cnt,
  output logic                 wr_en,
  output logic [AW-1:0]        wr_addr,
  output logic [DATA_BITS-1:0] wr_data
);
  logic [DATA_BITS-1:0] shreg_q;
  logic [CNTW-1:0]      cnt_q;

  assign byte_next = {shreg_q[DATA_BITS-2:0], bit_in};
  assign byte_cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (clear) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (take) begin
      shreg_q <= byte_next;
      if (close) cnt_q <= cnt_q + CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= take && close && !clear;
      if (take && close && !clear) begin
        wr_addr <= cnt_q[AW-1:0];
        wr_data <= byte_next;
      end
    end
  end
endmodule

// File: rtl/fr_packet_ctrl.sv
// Holds the length, the active state and the terminating flags of the packet.
module fr_packet_ctrl #(
  parameter int DATA_BITS = 8,
  parameter int MAX_BYTES = 38,
  parameter int LEN_BITS  = 5,
  parameter int CNTW      = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 data_take,
  input  logic                 byte_end,
  input  logic                 sync_fail,
  input  logic [DATA_BITS-1:0] byte_next,
  input  logic [CNTW-1:0]      byte_cnt,
  output logic                 ovf_hit,
  output logic                 active,
  output logic                 pkt_done,
  output logic [LEN_BITS-1:0]  pkt_len,
  output logic                 wrong_pkt,
  output logic                 overflow
);
  localparam int CMPW = ((CNTW > LEN_BITS) ? CNTW : LEN_BITS) + 1;

  logic [LEN_BITS-1:0] len_q, cand_len;
  logic [CMPW-1:0]     bytes_after;
  logic                done_hit, first_byte;

  always_comb begin
    ovf_hit     = data_take && (byte_cnt == CNTW'(MAX_BYTES));
    first_byte  = (byte_cnt == '0);
    cand_len    = first_byte ? byte_next[LEN_BITS-1:0] : len_q;
    bytes_after = CMPW'(byte_cnt) + CMPW'(1);
    done_hit    = byte_end && !ovf_hit && (cand_len != '0) &&
                  (bytes_after == CMPW'(cand_len));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      len_q     <= '0;
      pkt_done  <= 1'b0;
      pkt_len   <= '0;
      wrong_pkt <= 1'b0;
      overflow  <= 1'b0;
    end else if (frame_start) begin
      active    <= 1'b1;
      len_q     <= '0;
      pkt_done  <= 1'b0;
      pkt_len   <= '0;
      wrong_pkt <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      pkt_done <= done_hit;
      if (byte_end && first_byte) len_q <= cand_len;
      if (done_hit) pkt_len <= cand_len;
      if (sync_fail) wrong_pkt <= 1'b1;
      if (ovf_hit) overflow <= 1'b1;
      if (done_hit || sync_fail || ovf_hit) active <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_destuff_framer.sv
module sync_destuff_framer #(
  parameter int DATA_BITS = 8,
  parameter int SYNC_BITS = 3,
  parameter int ERR_LIMIT = 3,
  parameter int MAX_BYTES = 38,
  parameter int LEN_BITS  = 5,
  localparam int AW       = $clog2(MAX_BYTES),
  localparam int CNTW     = $clog2(MAX_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 bit_valid,
  input  logic                 bit_in,
  output logic                 wr_en,
  output logic [AW-1:0]        wr_addr,
  output logic [DATA_BITS-1:0] wr_data,
  output logic                 pkt_done,
  output logic [LEN_BITS-1:0]  pkt_len,
  output logic                 wrong_pkt,
  output logic                 overflow,
  output logic                 busy
);
  logic take, data_take, byte_end, sync_fail, ovf_hit;
  logic [DATA_BITS-1:0] byte_next;
  logic [CNTW-1:0]      byte_cnt;

  assign take = bit_valid && busy && !frame_start;

  fr_sync_tracker #(
    .DATA_BITS(DATA_BITS), .SYNC_BITS(SYNC_BITS), .ERR_LIMIT(ERR_LIMIT)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .clear(frame_start), .take(take), .bit_in(bit_in),
    .data_take(data_take), .byte_end(byte_end), .sync_fail(sync_fail)
  );

  fr_byte_assembler #(
    .DATA_BITS(DATA_BITS), .MAX_BYTES(MAX_BYTES), .AW(AW), .CNTW(CNTW)
  ) u_asm (
    .clk(clk), .rst_n(rst_n), .clear(frame_start),
    .take(data_take && !ovf_hit), .close(byte_end), .bit_in(bit_in),
    .byte_next(byte_next), .byte_cnt(byte_cnt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fr_packet_ctrl #(
    .DATA_BITS(DATA_BITS), .MAX_BYTES(MAX_BYTES), .LEN_BITS(LEN_BITS), .CNTW(CNTW)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .data_take(data_take), .byte_end(byte_end), .sync_fail(sync_fail),
    .byte_next(byte_next), .byte_cnt(byte_cnt), .ovf_hit(ovf_hit),
    .active(busy), .pkt_done(pkt_done), .pkt_len(pkt_len),
    .wrong_pkt(wrong_pkt), .overflow(overflow)
  );
endmodule

// File: rtl/sync_destuff_framer_chk.sv
module sync_destuff_framer_chk #(
  parameter int MAX_BYTES = 38,
  parameter int AW        = 6,
  parameter int LEN_BITS  = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_start,
  input logic                wr_en,
  input logic [AW-1:0]       wr_addr,
  input logic                pkt_done,
  input logic [LEN_BITS-1:0] pkt_len,
  input logic                wrong_pkt,
  input logic                overflow,
  input logic                busy
);
  p_write_needs_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(busy));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (busy && !wrong_pkt && !overflow && !wr_en && !pkt_done));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);

  p_done_last_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (wr_en && (32'(wr_addr) + 1 == 32'(pkt_len)) && !busy));

  p_wrong_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrong_pkt) |-> (!busy && !wr_en));

  p_no_overflow_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> (!busy && !wr_en));

  p_addr_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_addr) < MAX_BYTES));

  p_events_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_done, wrong_pkt, overflow}));
endmodule

bind sync_destuff_framer sync_destuff_framer_chk #(
  .MAX_BYTES(MAX_BYTES), .AW(AW), .LEN_BITS(LEN_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wr_en(wr_en),
  .wr_addr(wr_addr), .pkt_done(pkt_done), .pkt_len(pkt_len),
  .wrong_pkt(wrong_pkt), .overflow(overflow), .busy(busy)
);

// File: tb/sim_sync_destuff_framer.sv
module sim_sync_destuff_framer;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, frame_start, bit_valid, bit_in;
  logic wr_en, pkt_done, wrong_pkt, overflow, busy;
  logic [5:0] wr_addr;
  logic [7:0] wr_data;
  logic [4:0] pkt_len;

  int checks = 0;
  int errors = 0;
  int wcount = 0;
  int dcount = 0;
  logic [7:0] mem [0:63];

  sync_destuff_framer u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bit_valid(bit_valid),
    .bit_in(bit_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pkt_done(pkt_done), .pkt_len(pkt_len), .wrong_pkt(wrong_pkt),
    .overflow(overflow), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
      wcount <= wcount + 1;
    end
    if (pkt_done) dcount <= dcount + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in    = b;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bit_valid = 1'b0;
      frame_start = 1'b0;
    end
  endtask

  task automatic start_frame();
    @(negedge clk);
    bit_valid   = 1'b0;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int k = 7; k >= 0; k--) send_bit(v[k]);
  endtask

  function automatic logic [7:0] pbyte(input int len, input int i, input int p);
    if (i == 0) return {3'(p), 5'(len)};
    return 8'((len * 29 + i * 53 + p * 7) & 8'hFF);
  endfunction

  // clean packet: good sync groups between bytes
  task automatic send_packet(input int len, input int p, input int nbytes);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] v;
      v = pbyte(len, i, p);
      send_byte(v);
      if (i != nbytes - 1) begin
        send_bit(~v[0]);
        send_bit(i[0]);
        send_bit(i[1]);
      end
    end
    idle(2);
  endtask

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !wr_en && !pkt_done && !wrong_pkt && !overflow, "R1 reset outputs",
          int'({busy, wr_en, pkt_done, wrong_pkt, overflow}), 0);
    send_byte(8'h81); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); idle(2);
    check(wcount == 0, "R1 bits before frame start", wcount, 0);

    // R2 frame start arms; bit alongside frame_start dropped
    @(negedge clk); frame_start = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
    @(negedge clk); frame_start = 1'b0; bit_valid = 1'b0;
    check(busy && !wrong_pkt && !overflow, "R2 armed", int'(busy), 1);
    // byte 0 = 0x01 -> len 1; if the dropped bit had counted it would misalign
    begin
      int wb = wcount, db = dcount;
      send_byte(8'h01); idle(2);
      check(wcount == wb + 1 && mem[0] == 8'h01, "R2 same-cycle bit dropped", int'(mem[0]), 1);
      check(dcount == db + 1 && pkt_len == 5'd1, "R8 len 1 done", int'(pkt_len), 1);
    end

    // R3 R4 R8 R10 sweep over all non-zero lengths
    for (int len = 1; len < 32; len++) begin
      int wb, db, bad;
      start_frame();
      wb = wcount; db = dcount; bad = 0;
      send_packet(len, len, len);
      for (int i = 0; i < len; i++)
        if (mem[i] !== pbyte(len, i, len)) bad++;
      check(bad == 0, "R3 bytes MSB first", bad, 0);
      check(wcount - wb == len, "R4 sync bits not written", wcount - wb, len);
      check(dcount - db == 1 && pkt_len == 5'(len) && !busy, "R8 done at length",
            int'(pkt_len), len);
      wb = wcount;
      send_byte(8'hFF); send_byte(8'h00); idle(2);
      check(wcount == wb && dcount - db == 1, "R10 ignored after done", wcount - wb, 0);
    end

    // R5 R6 R7: two errors in each of two groups, packet still completes
    begin
      int wb, db;
      start_frame();
      wb = wcount; db = dcount;
      send_byte(8'h03);                           // last data bit 1
      send_bit(1'b1); send_bit(1'b1);             // two discarded sync bits
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      send_byte(8'hA4);                           // last data bit 0
      send_bit(1'b0); send_bit(1'b0);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
      send_byte(8'h5B); idle(2);
      check(wcount - wb == 3 && mem[1] == 8'hA4 && mem[2] == 8'h5B, "R5 discarded sync keeps alignment",
            int'(mem[2]), 'h5B);
      check(!wrong_pkt && dcount - db == 1, "R7 errors restart per group", int'(wrong_pkt), 0);
      check(pkt_len == 5'd3, "R6 unchecked sync bits", int'(pkt_len), 3);
    end

    // R7: third error in one group
    begin
      int wb;
      start_frame();
      wb = wcount;
      send_byte(8'h05);
      send_bit(1'b1); send_bit(1'b1); idle(2);
      check(!wrong_pkt && busy, "R7 two errors tolerated", int'(wrong_pkt), 0);
      send_bit(1'b1); idle(2);
      check(wrong_pkt && !busy, "R7 third error marks wrong", int'(wrong_pkt), 1);
      send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_byte(8'h77); idle(2);
      check(wcount - wb == 1 && wrong_pkt, "R10 ignored after wrong", wcount - wb, 1);
    end

    // R9: zero length runs to capacity, then overflows
    begin
      int wb, db;
      start_frame();
      wb = wcount; db = dcount;
      send_packet(0, 7, 38);
      check(wcount - wb == 38 && busy && !overflow, "R9 38 bytes accepted", wcount - wb, 38);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      send_bit(1'b0); idle(2);
      check(overflow && !busy, "R9 overflow set", int'(overflow), 1);
      check(wcount - wb == 38 && dcount == db, "R9 no write on overflow", wcount - wb, 38);
      send_byte(8'h3C); idle(2);
      check(wcount - wb == 38, "R10 ignored after overflow", wcount - wb, 38);
      // R2: restart clears flags
      start_frame();
      check(!overflow && busy, "R2 restart clears overflow", int'(overflow), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule